// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Force

This block collects single-cycle request pulses from on-chip sources such as timers and serial ports and holds each one in a pending bit. A mask register disables lines. The block presents the number of the most urgent enabled request to the processor as a small level code. Fifteen lines are numbered 1 to 15, and a higher number means a higher priority. The code 0 means that nothing is requested.

Software reaches the controller through a single-cycle register bus, with four registers at fixed offsets:
- Pending status can be read but not written.
- The mask can be read and written.
- A clear port, which is write-only, removes pending bits.
- A force register, which can be read and written, makes any line request without its source firing. Firmware uses it to test every line.

When the processor takes an interrupt, it acknowledges the level it was given, and that line's pending bit is dropped. A forced bit stays set until software removes it.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the pending and force registers read 0x0000, the mask reads 0xFFFE (every line disabled) and `irq_level` is 0.
- R2: A high `src_pulse[n]` for n in 1..15 sets pending bit n on that clock edge. Bit n of every register and of `src_pulse` stands for line n.
- R3: The pending register is read at offset 0x48. A bus write to 0x48 leaves it unchanged.
- R4: The mask register at offset 0x4C reads back what was written. A 1 in bit n keeps line n from reaching `irq_level`.
- R5: A write to offset 0x50 clears every pending bit whose data bit is 1 and leaves the others alone. Reading 0x50 returns 0.
- R6: The force register at offset 0x54 reads back what was written. A set bit n makes line n request exactly as if it were pending, and it remains set until software writes it to 0.
- R7: `irq_level` equals the highest-numbered line that is unmasked and is pending or forced, or 0 if there is none. It reflects register state one clock edge after the event that caused it.
- R8: A cycle with `irq_ack` high clears pending bit `ack_level`. It does not change the force register.
- R9: If a source pulse arrives in the same cycle as a clear write or an acknowledge for the same line, the pulse wins and the line stays pending.
- R10: Reads at any other offset return 0, and writes there change no register.
- R11: Bit 0 has no line. It reads 0 in all registers, and `src_pulse[0]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data, bit n = line n |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| src_pulse | input | 16 | Source request pulses, bit n = line n |
| irq_ack | input | 1 | Processor acknowledge |
| ack_level | input | 4 | Line being acknowledged |
| irq_level | output | 4 | Highest active line, 0 = none |

## Verification
A corrupted pending, mask or force bit shows up on `irq_level` on the very next clock edge, whenever it belongs to the highest enabled line. When it sits under a higher active line, it stays hidden until that line is masked or acknowledged. Every register can also be read back over the bus in the cycle after it changes. For that reason the bench reads the registers back after each stimulus in addition to watching the level. The bench sweeps every pair of lines for priority and every mask threshold, so that a bit that is buried under a higher line is still exposed.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_CLR,
        SEL_FORCE
    } reg_sel_e;

endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
    import irq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_PEND  = 8'h48,
    parameter logic [ADDR_W-1:0] OFF_MASK  = 8'h4C,
    parameter logic [ADDR_W-1:0] OFF_CLR   = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_FORCE = 8'h54
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == OFF_PEND)       sel = SEL_PEND;
        else if (addr == OFF_MASK)  sel = SEL_MASK;
        else if (addr == OFF_CLR)   sel = SEL_CLR;
        else if (addr == OFF_FORCE) sel = SEL_FORCE;
        else                        sel = SEL_NONE;
    end

endmodule

// File: rtl/irq_state.sv
module irq_state
    import irq_pkg::*;
#(
    parameter int NL = 15,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  reg_sel_e      sel,
    input  logic          we,
    input  logic [NL:0]   wdata,
    input  logic [NL:0]   src,
    input  logic          ack,
    input  logic [LW-1:0] ack_lvl,
    output logic [NL:0]   pend_q,
    output logic [NL:0]   mask_q,
    output logic [NL:0]   force_q
);

    // bit 0 carries no line
    localparam logic [NL:0] LINES = {{NL{1'b1}}, 1'b0};

    typedef struct packed {
        logic [NL:0] pend;
        logic [NL:0] mask;
        logic [NL:0] frc;
    } st_t;

    st_t         st_d, st_q;
    logic [NL:0] ack_vec;
    logic [NL:0] clr_vec;

    always_comb begin
        ack_vec = ack ? ({{NL{1'b0}}, 1'b1} << ack_lvl) : '0;
        clr_vec = (we && sel == SEL_CLR) ? wdata : '0;
        st_d    = st_q;
        // new pulses are ORed in after removal, so a same-cycle pulse wins
        st_d.pend = ((st_q.pend & ~clr_vec & ~ack_vec) | src) & LINES;
        if (we && sel == SEL_MASK)  st_d.mask = wdata & LINES;
        if (we && sel == SEL_FORCE) st_d.frc  = wdata & LINES;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= LINES;
            st_q.frc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q  = st_q.pend;
    assign mask_q  = st_q.mask;
    assign force_q = st_q.frc;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NL = 15,
    parameter int LW = 4
) (
    input  logic [NL:0]   req,
    output logic [LW-1:0] level
);

    // later (higher) lines overwrite earlier ones
    always_comb begin
        level = '0;
        for (int i = 0; i <= NL; i++) begin
            if (req[i]) level = LW'(i);
        end
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter int                NL        = 15,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_PEND  = 8'h48,
    parameter logic [ADDR_W-1:0] OFF_MASK  = 8'h4C,
    parameter logic [ADDR_W-1:0] OFF_CLR   = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_FORCE = 8'h54,
    localparam int               LW        = $clog2(NL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NL:0]       bus_wdata,
    output logic [NL:0]       bus_rdata,
    input  logic [NL:0]       src_pulse,
    input  logic              irq_ack,
    input  logic [LW-1:0]     ack_level,
    output logic [LW-1:0]     irq_level
);

    reg_sel_e    sel;
    logic [NL:0] pend_q;
    logic [NL:0] mask_q;
    logic [NL:0] force_q;
    logic [NL:0] active;

    irq_bus_dec #(
        .ADDR_W   (ADDR_W),
        .OFF_PEND (OFF_PEND),
        .OFF_MASK (OFF_MASK),
        .OFF_CLR  (OFF_CLR),
        .OFF_FORCE(OFF_FORCE)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    irq_state #(
        .NL(NL),
        .LW(LW)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .src    (src_pulse),
        .ack    (irq_ack),
        .ack_lvl(ack_level),
        .pend_q (pend_q),
        .mask_q (mask_q),
        .force_q(force_q)
    );

    assign active = (pend_q | force_q) & ~mask_q;

    irq_prio_enc #(
        .NL(NL),
        .LW(LW)
    ) u_enc (
        .req  (active),
        .level(irq_level)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND:  bus_rdata = pend_q;
            SEL_MASK:  bus_rdata = mask_q;
            SEL_FORCE: bus_rdata = force_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int                NL        = 15,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFF_PEND  = 8'h48,
    parameter logic [ADDR_W-1:0] OFF_CLR   = 8'h50,
    parameter logic [ADDR_W-1:0] OFF_FORCE = 8'h54,
    parameter int                LW        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NL:0]       bus_wdata,
    input logic [NL:0]       src_pulse,
    input logic              irq_ack,
    input logic [LW-1:0]     ack_level,
    input logic [LW-1:0]     irq_level,
    input logic [NL:0]       pend_q,
    input logic [NL:0]       mask_q,
    input logic [NL:0]       force_q
);

    logic [NL:0] act;
    assign act = (pend_q | force_q) & ~mask_q;

    genvar n;
    generate
        for (n = 1; n <= NL; n++) begin : g_line
            assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                src_pulse[n] |=> pend_q[n]);

            assert_clear_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == OFF_CLR && bus_wdata[n] && !src_pulse[n])
                |=> !pend_q[n]);

            assert_level_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (act[n] && irq_level < LW'(n)) |-> 1'b0);
        end
    endgenerate

    assert_pend_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_PEND && !irq_ack && src_pulse == '0)
        |=> $stable(pend_q));

    assert_force_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFF_FORCE) |=> $stable(force_q));

    assert_level_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> act[irq_level]);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !src_pulse[ack_level]) |=> !pend_q[$past(ack_level)]);

    assert_bit0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_q[0] || mask_q[0] || force_q[0]));

endmodule

bind irq_ctrl_top irq_ctrl_chk #(
    .NL       (NL),
    .ADDR_W   (ADDR_W),
    .OFF_PEND (OFF_PEND),
    .OFF_CLR  (OFF_CLR),
    .OFF_FORCE(OFF_FORCE),
    .LW       (LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .src_pulse(src_pulse),
    .irq_ack  (irq_ack),
    .ack_level(ack_level),
    .irq_level(irq_level),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .force_q  (force_q)
);

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;

    localparam logic [7:0] A_PEND  = 8'h48;
    localparam logic [7:0] A_MASK  = 8'h4C;
    localparam logic [7:0] A_CLR   = 8'h50;
    localparam logic [7:0] A_FORCE = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] src_pulse = '0;
    logic        irq_ack = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_pulse(src_pulse),
        .irq_ack  (irq_ack),
        .ack_level(ack_level),
        .irq_level(irq_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one clock of stimulus, then idle; returns at a falling edge
    task automatic cyc(input logic [7:0] a, input logic we, input logic [15:0] d,
                       input logic [15:0] src, input logic ack, input logic [3:0] al);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        src_pulse = src; irq_ack = ack; ack_level = al;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; src_pulse = '0; irq_ack = 1'b0; ack_level = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cyc(a, 1'b1, d, 16'h0, 1'b0, 4'd0);
    endtask

    task automatic pulse(input logic [15:0] src);
        cyc(8'h00, 1'b0, 16'h0, src, 1'b0, 4'd0);
    endtask

    task automatic ack(input logic [3:0] l);
        cyc(8'h00, 1'b0, 16'h0, 16'h0, 1'b1, l);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    task automatic chk_lvl(input int exp, input string req);
        check(irq_level === 4'(exp), req, irq_level, exp);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg(A_PEND, 16'h0000, "R1 pend");
        chk_reg(A_MASK, 16'hFFFE, "R1 mask");
        chk_reg(A_FORCE, 16'h0000, "R1 force");
        chk_lvl(0, "R1 level");

        // R10 unmapped offsets
        chk_reg(8'h00, 16'h0, "R10 read 0x00");
        wr(8'h58, 16'h1234);
        chk_reg(8'h58, 16'h0, "R10 read 0x58");
        chk_reg(A_MASK, 16'hFFFE, "R10 mask untouched");
        chk_reg(A_FORCE, 16'h0000, "R10 force untouched");

        // R4 mask read-write
        wr(A_MASK, 16'h0000);
        chk_reg(A_MASK, 16'h0000, "R4 mask write");

        // R2 R7 R8 each line alone
        for (int n = 1; n <= 15; n++) begin
            pulse(16'(1 << n));
            chk_reg(A_PEND, 16'(1 << n), "R2 pend set");
            chk_lvl(n, "R7 single line");
            ack(4'(n));
            chk_reg(A_PEND, 16'h0, "R8 ack clears");
            chk_lvl(0, "R8 level after ack");
        end

        // R7 priority over every pair, R5 clear all
        for (int i = 1; i <= 15; i++) begin
            for (int j = 1; j <= 15; j++) begin
                pulse(16'((1 << i) | (1 << j)));
                chk_lvl((i > j) ? i : j, "R7 pair priority");
                wr(A_CLR, 16'hFFFF);
                chk_reg(A_PEND, 16'h0, "R5 clear all");
            end
        end

        // R4 mask thresholds: all lines pending, lines above k masked
        pulse(16'hFFFE);
        for (int k = 0; k <= 15; k++) begin
            wr(A_MASK, 16'(~((32'h1 << (k + 1)) - 1)) & 16'hFFFE);
            chk_lvl(k, "R4 mask threshold");
        end
        wr(A_MASK, 16'hFFFE);
        chk_lvl(0, "R4 all masked");
        chk_reg(A_PEND, 16'hFFFE, "R4 mask keeps pending");
        wr(A_MASK, 16'h0000);

        // R5 selective clear, reads zero
        wr(A_CLR, 16'h5554);
        chk_reg(A_PEND, 16'hAAAA, "R5 selective clear");
        chk_lvl(15, "R5 level after partial clear");
        chk_reg(A_CLR, 16'h0, "R5 clear reads zero");
        wr(A_CLR, 16'hFFFF);

        // R3 pending is read-only
        pulse(16'h0020);
        wr(A_PEND, 16'h0000);
        chk_reg(A_PEND, 16'h0020, "R3 write zero ignored");
        wr(A_PEND, 16'hFFFF);
        chk_reg(A_PEND, 16'h0020, "R3 write ones ignored");
        chk_lvl(5, "R3 level unchanged");
        wr(A_CLR, 16'h0020);

        // R6 force every line, survives acknowledge
        for (int n = 1; n <= 15; n++) begin
            wr(A_FORCE, 16'(1 << n));
            chk_reg(A_FORCE, 16'(1 << n), "R6 force readback");
            chk_lvl(n, "R6 forced level");
            chk_reg(A_PEND, 16'h0, "R6 force not pending");
            ack(4'(n));
            chk_reg(A_FORCE, 16'(1 << n), "R8 ack keeps force");
            chk_lvl(n, "R6 force holds");
            wr(A_FORCE, 16'h0);
            chk_lvl(0, "R6 force removed");
        end
        wr(A_MASK, 16'h8000);
        wr(A_FORCE, 16'h8000);
        chk_lvl(0, "R6 masked force");
        wr(A_FORCE, 16'h0);
        wr(A_MASK, 16'h0000);

        // R9 pulse beats clear and ack on the same line
        cyc(A_CLR, 1'b1, 16'h0080, 16'h0080, 1'b0, 4'd0);
        chk_reg(A_PEND, 16'h0080, "R9 pulse beats clear");
        cyc(8'h00, 1'b0, 16'h0, 16'h0080, 1'b1, 4'd7);
        chk_reg(A_PEND, 16'h0080, "R9 pulse beats ack");
        chk_lvl(7, "R9 level");
        wr(A_CLR, 16'hFFFF);

        // R11 bit 0 carries nothing
        pulse(16'h0001);
        chk_reg(A_PEND, 16'h0, "R11 src bit0");
        chk_lvl(0, "R11 level bit0");
        wr(A_FORCE, 16'h0001);
        chk_reg(A_FORCE, 16'h0, "R11 force bit0");
        wr(A_MASK, 16'h0001);
        chk_reg(A_MASK, 16'h0, "R11 mask bit0");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule